// File: doc/BRIEF.md
# Cross-Domain Timer Interrupt Flag Unit

This block keeps the two interrupt flags of a timer whose counter runs on a slow clock that has no fixed phase relation to the processor clock. The flags are compare match and overflow. The timer side supplies one-cycle event pulses on its own clock. Each pulse is carried into the processor domain through a toggle synchronizer, and an edge detector on the processor side sets the matching flag. The flag is visible a fixed time after the event: one timer cycle plus three processor cycles.

Software sees an 8-bit flag register and an 8-bit enable register. Writing a one to a flag bit clears that flag. The interrupt controller can also clear one flag with a one-cycle acknowledge pulse and a source select. Each request output is high while the global enable, the source's enable bit and its flag are all set. When a set and a clear land in the same processor cycle, the set wins, so no event is lost.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, `flags_o`, `enables_o` and `irq_o` are all zero.
- R2: A `cmp_evt_i` pulse sets flag bit 1, and an `ovf_evt_i` pulse sets flag bit 0. Let the first `tclk_i` rising edge that sees the pulse high be the sampling edge. The flag shows on `flags_o` after the third `clk_i` rising edge that follows the next `tclk_i` rising edge after the sampling edge, and not before that edge.
- R3: A write with `wr_i`=1 and `wr_sel_i`=1 (flag register) clears each of flag bits 1:0 whose data bit is one. Flag bits with a zero data bit keep their value.
- R4: An `ack_i` pulse clears only the flag chosen by `ack_src_i`, where 1 selects compare (bit 1) and 0 selects overflow (bit 0). The other flag is unchanged.
- R5: `irq_o[i]` is `gie_i & enables_o[i] & flags_o[i]` for i in 0..1. When `gie_i` is 0, `irq_o` is zero.
- R6: When a flag's set event takes effect in the same `clk_i` cycle as a write-one clear or an acknowledge of that flag, the flag ends the cycle set.
- R7: A write with `wr_i`=1 and `wr_sel_i`=0 (enable register) loads `enables_o[1:0]` from data bits 1:0. Bits 7:2 of both registers always read zero, and writes to them have no effect.
- R8: Compare and overflow events on the same timer edge set both flags independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| tclk_i | input | 1 | Timer clock |
| cmp_evt_i | input | 1 | Compare match pulse, timer domain |
| ovf_evt_i | input | 1 | Overflow pulse, timer domain |
| wr_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = enable register, 1 = flag register |
| wr_data_i | input | 8 | Write data |
| ack_i | input | 1 | Vector acknowledge pulse |
| ack_src_i | input | 1 | Acknowledged source: 1 compare, 0 overflow |
| gie_i | input | 1 | Global interrupt enable |
| flags_o | output | 8 | Flag register |
| enables_o | output | 8 | Enable register |
| irq_o | output | 2 | Requests: bit 1 compare, bit 0 overflow |

## Verification
The bench pins down the exact cycle in which a flag appears after a timer event. A synchronizer with a missing or an extra stage would show the flag one processor cycle early or late. It also drives a write-one clear and an acknowledge into the very cycle in which the set lands. A design with clear priority would drop that event and read back zero. It writes zero data, writes to the upper bits, and acknowledges the wrong source. A design that cleared too widely, or stored bits it should ignore, would lose or corrupt the other flag or show nonzero upper bits.

// File: rtl/tif_pkg.sv
package tif_pkg;
  localparam int SRC_OVF = 0;
  localparam int SRC_CMP = 1;
  localparam int N_SRC   = 2;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAG   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tif_evt_sync.sv
module tif_evt_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic tclk_i,
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  output logic set_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic evt_q, tgl_q;
  logic [MSB:0] sync_q;
  logic last_q;

  // timer domain: sample pulse, flip toggle one timer cycle later
  always_ff @(posedge tclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      tgl_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      if (evt_q) tgl_q <= ~tgl_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], tgl_q};
      last_q <= sync_q[MSB];
    end
  end

  assign set_o = sync_q[MSB] ^ last_q;
endmodule

// File: rtl/tif_flag_bank.sv
module tif_flag_bank #(
  parameter int N_SRC = 2,
  parameter int REG_W = 8,
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic             wr_flag_i,
  input  logic             wr_enable_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic [SRC_W-1:0] ack_src_i,
  input  logic             gie_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] enables_o,
  output logic [N_SRC-1:0] irq_o
);
  logic [N_SRC-1:0] flag_q, en_q, clr;
  logic unused_hi;

  assign unused_hi = ^wr_data_i[REG_W-1:N_SRC];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign clr[i] = (wr_flag_i & wr_data_i[i]) |
                    (ack_i & (ack_src_i == SRC_W'(i)));

    // set beats clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr[i])   flag_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          en_q <= '0;
    else if (wr_enable_i) en_q <= wr_data_i[N_SRC-1:0];
  end

  assign flags_o   = {{(REG_W-N_SRC){1'b0}}, flag_q};
  assign enables_o = {{(REG_W-N_SRC){1'b0}}, en_q};
  assign irq_o     = {N_SRC{gie_i}} & en_q & flag_q;
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tclk_i,
  input  logic             cmp_evt_i,
  input  logic             ovf_evt_i,
  input  logic             wr_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             ack_i,
  input  logic             ack_src_i,
  input  logic             gie_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] enables_o,
  output logic [1:0]       irq_o
);
  import tif_pkg::*;

  logic [N_SRC-1:0] evt_in, evt_set;

  assign evt_in[SRC_OVF] = ovf_evt_i;
  assign evt_in[SRC_CMP] = cmp_evt_i;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    tif_evt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .tclk_i (tclk_i),
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt_in[i]),
      .set_o  (evt_set[i])
    );
  end

  tif_flag_bank #(.N_SRC(N_SRC), .REG_W(REG_W)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (evt_set),
    .wr_flag_i   (wr_i & (wr_sel_i == SEL_FLAG)),
    .wr_enable_i (wr_i & (wr_sel_i == SEL_ENABLE)),
    .wr_data_i   (wr_data_i),
    .ack_i       (ack_i),
    .ack_src_i   (ack_src_i),
    .gie_i       (gie_i),
    .flags_o     (flags_o),
    .enables_o   (enables_o),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             wr_sel_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             ack_i,
  input logic             ack_src_i,
  input logic             gie_i,
  input logic [REG_W-1:0] flags_o,
  input logic [REG_W-1:0] enables_o,
  input logic [1:0]       irq_o,
  input logic [1:0]       set_i
);
  for (genvar i = 0; i < 2; i++) begin : g_chk
    // R2: a flag only rises after a synchronized event
    a_r2_rise_needs_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flags_o[i]) |-> $past(set_i[i]));
    // R6: set wins
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
    // R3: write one clears
    a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wr_sel_i && wr_data_i[i] && !set_i[i]) |=> !flags_o[i]);
    // R3: zero bit keeps value
    a_r3_w0_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && wr_sel_i && !wr_data_i[i] && !set_i[i] &&
       !(ack_i && (ack_src_i == i[0]))) |=> $stable(flags_o[i]));
    // R4: ack clears selected only
    a_r4_ack_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && (ack_src_i == i[0]) && !set_i[i]) |=> !flags_o[i]);
    // R5: request needs its flag and enable
    a_r5_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> (flags_o[i] && enables_o[i]));
  end

  a_r5_gie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (irq_o == 2'b00));
  a_r7_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o[REG_W-1:2] == '0) && (enables_o[REG_W-1:2] == '0));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.REG_W(REG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .ack_i     (ack_i),
  .ack_src_i (ack_src_i),
  .gie_i     (gie_i),
  .flags_o   (flags_o),
  .enables_o (enables_o),
  .irq_o     (irq_o),
  .set_i     (evt_set)
);

// File: tb/tmr_irq_flags_tb.sv
module tmr_irq_flags_tb;
  localparam int CLK_HALF  = 5;   // processor period 10
  localparam int TCLK_HALF = 40;  // timer period 80

  logic clk_i = 1'b0, tclk_i = 1'b0, rst_ni = 1'b0;
  logic cmp_evt_i = 1'b0, ovf_evt_i = 1'b0;
  logic wr_i = 1'b0, wr_sel_i = 1'b0, ack_i = 1'b0, ack_src_i = 1'b0, gie_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] flags_o, enables_o;
  logic [1:0] irq_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  tmr_irq_flags u_dut (.*);

  always #CLK_HALF clk_i = ~clk_i;
  initial begin
    #TCLK_HALF;
    forever #TCLK_HALF tclk_i = ~tclk_i;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // op: 0 none, 1 flag write, 2 enable write, 3 ack (src = data[0])
  typedef struct packed {
    logic [1:0] evts;  // {cmp, ovf}
    logic [1:0] op;
    logic [7:0] data;
    logic       gie;
    logic [7:0] ef;
    logic [7:0] ee;
    logic [1:0] ei;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{2'b11, 2'd0, 8'h00, 1'b0, 8'h03, 8'h00, 2'b00},  // R8
    '{2'b00, 2'd2, 8'hFF, 1'b1, 8'h03, 8'h03, 2'b11},  // R7 R5
    '{2'b00, 2'd1, 8'h00, 1'b1, 8'h03, 8'h03, 2'b11},  // R3 zero
    '{2'b00, 2'd1, 8'h02, 1'b1, 8'h01, 8'h03, 2'b01},  // R3
    '{2'b00, 2'd3, 8'h00, 1'b1, 8'h00, 8'h03, 2'b00},  // R4
    '{2'b10, 2'd0, 8'h00, 1'b0, 8'h02, 8'h03, 2'b00},  // R5 gie off
    '{2'b00, 2'd2, 8'h01, 1'b1, 8'h02, 8'h01, 2'b00},  // R7
    '{2'b01, 2'd3, 8'h01, 1'b1, 8'h01, 8'h01, 2'b01},  // R4 cmp only
    '{2'b00, 2'd1, 8'hFC, 1'b1, 8'h01, 8'h01, 2'b01},  // R7 upper
    '{2'b00, 2'd2, 8'h00, 1'b1, 8'h01, 8'h00, 2'b00},  // R5
    '{2'b00, 2'd1, 8'h03, 1'b1, 8'h00, 8'h00, 2'b00}   // R3
  };

  // returns at sampling edge + 80 (the toggle edge), pulses removed
  task automatic fire(input logic [1:0] e);
    @(negedge tclk_i);
    cmp_evt_i = e[1];
    ovf_evt_i = e[0];
    @(posedge tclk_i);
    @(negedge tclk_i);
    cmp_evt_i = 1'b0;
    ovf_evt_i = 1'b0;
    @(posedge tclk_i);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [7:0] d);
    @(negedge clk_i);
    wr_data_i = d;
    case (op)
      2'd1: begin wr_i = 1'b1; wr_sel_i = 1'b1; end
      2'd2: begin wr_i = 1'b1; wr_sel_i = 1'b0; end
      2'd3: begin ack_i = 1'b1; ack_src_i = d[0]; end
      default: ;
    endcase
    @(negedge clk_i);
    wr_i = 1'b0; ack_i = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    #4;
    chk("R1 flags", flags_o, 0);
    chk("R1 enables", enables_o, 0);
    chk("R1 irq", irq_o, 0);

    foreach (VT[k]) begin
      gie_i = VT[k].gie;
      if (VT[k].evts != 2'b00) begin
        fire(VT[k].evts);
        #40;
      end
      do_op(VT[k].op, VT[k].data);
      chk($sformatf("R3-R8 vec%0d flags", k), flags_o, VT[k].ef);
      chk($sformatf("R7 vec%0d enables", k), enables_o, VT[k].ee);
      chk($sformatf("R5 vec%0d irq", k), irq_o, VT[k].ei);
    end

    // R2 exact latency, compare source
    fire(2'b10);
    #22 chk("R2 cmp not before third edge", flags_o[1], 0);
    #10 chk("R2 cmp after third edge", flags_o[1], 1);
    do_op(2'd1, 8'h03);
    // R2 exact latency, overflow source
    fire(2'b01);
    #22 chk("R2 ovf not before third edge", flags_o[0], 0);
    #10 chk("R2 ovf after third edge", flags_o[0], 1);
    do_op(2'd1, 8'h03);
    chk("R3 cleared before collision", flags_o, 0);

    // R6 set vs write-one in same cycle
    fire(2'b10);
    #20;
    wr_i = 1'b1; wr_sel_i = 1'b1; wr_data_i = 8'h02;
    #10;
    wr_i = 1'b0;
    #2 chk("R6 set beats write-one", flags_o[1], 1);
    // R6 set vs ack in same cycle
    fire(2'b01);
    #20;
    ack_i = 1'b1; ack_src_i = 1'b0;
    #10;
    ack_i = 1'b0;
    #2 chk("R6 set beats ack", flags_o[0], 1);
    // R4 ack overflow leaves compare
    do_op(2'd3, 8'h00);
    chk("R4 ack ovf keeps cmp", flags_o, 8'h02);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule